// File: doc/BRIEF.md
# In-Band Graphics Port Request Issuer

This block is the master-side request launcher for a graphics port that shares an address/data bus with a conventional parallel bus. Memory requests wait in a local FIFO, each with a command code, an 8-byte-aligned 64-bit address and a 3-bit length code. When a request is waiting and the target's request queue has room, the issuer asserts the active-low bus request. It waits until the arbiter grants the bus with the "request issue" status code. It then places one request per cycle on the command and address lines, marking each with an active-low pipeline strobe. No per-request handshake is used.

A request whose address is at or above 4 GiB takes two bus words. The first word carries the dual-address command with the low address and length, and the second carries the real command with the upper 32 address bits. Both words together use one queue slot. A fence uses no slot, and a flush uses one. The issuer counts outstanding slot-consuming requests against a depth limit that software programs, and frees one slot per completion pulse from the response side. When the limit is reached, the issuer ends the burst early. It releases the bus request on the last word and the strobe one cycle later.

Top module: `inband_req_issuer`

## Requirements
- R1: After reset, `req_n` and `pipe_n` are high, `bus_cmd` and `bus_ad` are zero, and the programmed depth is 0.
- R2: While the programmed depth is 0, `req_n` and `pipe_n` stay high whatever the FIFO holds.
- R3: The first word of a burst appears on the bus (with `pipe_n` low) only in the cycle after a rising clock edge at which `gnt_n` was low and `bus_status` was 3'b111. A grant with any other status, or a status of 3'b111 without `gnt_n` low, starts nothing.
- R4: A single-word request drives `bus_cmd` with the request's 4-bit command and `bus_ad` with {address bits 31:3, length code}. The command codes are: read 0000/0001, write 0100/0101, long read 1000/1001 (bit 0 set means high priority), flush 1010 and fence 1100. Words go out in FIFO order.
- R5: Within a burst, successive words occupy consecutive cycles, and `pipe_n` is low in each of them.
- R6: `req_n` rises in the same cycle as the last word of a burst. `pipe_n` is high in the cycle that follows.
- R7: A read, write or long read whose address bits 63:32 are nonzero is sent as two consecutive words. The first is `bus_cmd`=1101 with {address 31:3, length}. The second is the request's own command with `bus_ad`=address bits 63:32. The pair consumes one slot.
- R8: The number of outstanding slot-consuming requests never exceeds the programmed depth. Each cycle with `slot_free` high releases one slot.
- R9: When the outstanding count reaches the depth, the burst ends at that word even though more requests are queued. Issue resumes through a new request and grant once a slot is freed.
- R10: A fence is sent even when every slot is taken, and it consumes no slot. A flush consumes one slot and is never split into two words, whatever its address.
- R11: A depth write (`cfg_we`) takes effect only when the issuer is idle, with `req_n` and `pipe_n` both high. A write at any other time is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Depth register write strobe |
| cfg_depth | input | DEPTH_W | New maximum outstanding request count |
| in_valid | input | 1 | FIFO head holds a request |
| in_cmd | input | 4 | Command code of the FIFO head |
| in_addr | input | 61 | Address bits 63:3 of the FIFO head |
| in_len | input | 3 | Length code (bytes = 8 × (code+1), ×4 for long read) |
| in_pop | output | 1 | Removes the FIFO head this cycle |
| gnt_n | input | 1 | Active-low bus grant |
| bus_status | input | 3 | Bus status code qualifying the grant |
| slot_free | input | 1 | Completion pulse; frees one outstanding slot |
| req_n | output | 1 | Active-low bus request |
| pipe_n | output | 1 | Active-low request strobe |
| bus_cmd | output | 4 | Request command lines |
| bus_ad | output | 32 | Request address/length lines |

## Verification
A wrong outstanding count shows up in one of two ways. The issuer may stop a burst early and hold `req_n` high while requests wait, which is visible within a few cycles. Or it may launch more slot-consuming words than the depth permits before any completion arrives. Mis-tracked dual-address phases show on the very next word as a missing or repeated 1101 command. A stale staging entry shows as a word that breaks FIFO order. A wrong release sequence appears at the burst's final word, where `req_n` and `pipe_n` must change one cycle apart.

// File: rtl/inband_req_issuer.sv
module inband_req_issuer #(
  parameter int DEPTH_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [DEPTH_W-1:0] cfg_depth,
  input  logic               in_valid,
  input  logic [3:0]         in_cmd,
  input  logic [63:3]        in_addr,
  input  logic [2:0]         in_len,
  output logic               in_pop,
  input  logic               gnt_n,
  input  logic [2:0]         bus_status,
  input  logic               slot_free,
  output logic               req_n,
  output logic               pipe_n,
  output logic [3:0]         bus_cmd,
  output logic [31:0]        bus_ad
);

  localparam logic [3:0] CMD_FLUSH = 4'b1010;
  localparam logic [3:0] CMD_FENCE = 4'b1100;
  localparam logic [3:0] CMD_DUAL  = 4'b1101;
  localparam int         CW        = DEPTH_W + 1;

  typedef enum logic [1:0] {S_IDLE, S_ARB, S_BURST} state_t;

  state_t             state;
  logic [DEPTH_W-1:0] depth_q, cnt_q;
  logic               stg_v, dac_ph;
  logic [3:0]         stg_cmd;
  logic [63:3]        stg_addr;
  logic [2:0]         stg_len;

  logic stg_dual, stg_slot, room, stg_ok, granted, issue;
  logic first_dual, final_w, inc, dec, nxt_ok, last;
  logic [CW-1:0] cnt_after;
  logic [3:0]  w_cmd;
  logic [31:0] w_ad;

  assign stg_dual   = (stg_addr[63:32] != 32'd0) && (stg_cmd != CMD_FLUSH) && (stg_cmd != CMD_FENCE);
  assign stg_slot   = (stg_cmd != CMD_FENCE);
  assign room       = (cnt_q < depth_q);
  assign stg_ok     = stg_v && (depth_q != '0) && (!stg_slot || room || dac_ph);
  assign granted    = !gnt_n && (bus_status == 3'b111);
  assign issue      = (state == S_ARB && granted) || (state == S_BURST);

  assign first_dual = stg_dual && !dac_ph;
  assign final_w    = !first_dual;
  assign w_cmd      = first_dual ? CMD_DUAL : stg_cmd;
  assign w_ad       = (stg_dual && dac_ph) ? stg_addr[63:32] : {stg_addr[31:3], stg_len};

  assign inc        = issue && stg_slot && !dac_ph;
  assign dec        = slot_free && (cnt_q != '0);
  assign cnt_after  = {1'b0, cnt_q} + CW'(inc);
  assign nxt_ok     = in_valid && ((in_cmd == CMD_FENCE) || (cnt_after < {1'b0, depth_q}));
  assign last       = final_w && !nxt_ok;
  assign in_pop     = in_valid && (!stg_v || (issue && final_w));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      req_n    <= 1'b1;
      pipe_n   <= 1'b1;
      bus_cmd  <= '0;
      bus_ad   <= '0;
      depth_q  <= '0;
      cnt_q    <= '0;
      stg_v    <= 1'b0;
      dac_ph   <= 1'b0;
      stg_cmd  <= '0;
      stg_addr <= '0;
      stg_len  <= '0;
    end else begin
      cnt_q <= cnt_q + DEPTH_W'(inc) - DEPTH_W'(dec);

      if (in_pop) begin
        stg_v    <= 1'b1;
        stg_cmd  <= in_cmd;
        stg_addr <= in_addr;
        stg_len  <= in_len;
      end else if (issue && final_w) begin
        stg_v <= 1'b0;
      end

      if (issue) begin
        dac_ph  <= first_dual;
        pipe_n  <= 1'b0;
        bus_cmd <= w_cmd;
        bus_ad  <= w_ad;
        if (last) begin
          req_n <= 1'b1;
          state <= S_IDLE;
        end else begin
          state <= S_BURST;
        end
      end else begin
        pipe_n  <= 1'b1;
        bus_cmd <= '0;
        bus_ad  <= '0;
        if (state == S_IDLE && pipe_n) begin
          if (cfg_we) begin
            depth_q <= cfg_depth;
          end else if (stg_ok) begin
            req_n <= 1'b0;
            state <= S_ARB;
          end
        end
      end
    end
  end

  assert_quiet_depth0_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (depth_q == '0) |-> (req_n && pipe_n));

  assert_grant_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pipe_n) |-> $past(!gnt_n && bus_status == 3'b111));

  assert_strobe_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_n && req_n) |=> pipe_n);

  assert_dual_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_n && bus_cmd == CMD_DUAL) |=> (!pipe_n && bus_cmd != CMD_DUAL));

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q > $past(cnt_q)) |-> (cnt_q <= depth_q));

endmodule

// File: tb/inband_req_issuer_bench.sv
module inband_req_issuer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH_W    = 8;
  localparam logic [3:0] C_FLUSH = 4'b1010;
  localparam logic [3:0] C_FENCE = 4'b1100;
  localparam logic [3:0] C_DUAL  = 4'b1101;
  localparam logic [3:0] CODES [8] = '{4'b0000, 4'b0001, 4'b0100, 4'b0101,
                                       4'b1000, 4'b1001, C_FLUSH, C_FENCE};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [DEPTH_W-1:0] cfg_depth = '0;
  logic in_valid, in_pop;
  logic [3:0] in_cmd;
  logic [63:3] in_addr;
  logic [2:0] in_len;
  logic gnt_n = 1'b1;
  logic [2:0] bus_status = 3'b000;
  logic slot_free = 1'b0;
  logic req_n, pipe_n;
  logic [3:0] bus_cmd;
  logic [31:0] bus_ad;

  always #(CLK_PERIOD/2) clk = ~clk;

  inband_req_issuer #(.DEPTH_W(DEPTH_W)) u_inband_req_issuer (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_depth(cfg_depth),
    .in_valid(in_valid), .in_cmd(in_cmd), .in_addr(in_addr), .in_len(in_len),
    .in_pop(in_pop), .gnt_n(gnt_n), .bus_status(bus_status), .slot_free(slot_free),
    .req_n(req_n), .pipe_n(pipe_n), .bus_cmd(bus_cmd), .bus_ad(bus_ad));

  logic [3:0]  q_cmd  [256];
  logic [63:3] q_addr [256];
  logic [2:0]  q_len  [256];
  int q_n = 0, q_rd = 0;
  assign in_valid = (q_rd < q_n);
  assign in_cmd   = q_cmd[q_rd[7:0]];
  assign in_addr  = q_addr[q_rd[7:0]];
  assign in_len   = q_len[q_rd[7:0]];
  always @(posedge clk) if (in_pop) q_rd <= q_rd + 1;

  logic [3:0]  e_cmd  [256];
  logic [31:0] e_ad   [256];
  logic        e_slot [256];
  logic        e_dual [256];
  int exp_n = 0, obs_i = 0;
  int model_cnt = 0, depth_model = 0;
  int checks = 0, failures = 0, cyc = 0;
  logic g_edge = 1'b0, prev_pipe = 1'b1, prev_req = 1'b1;

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push_req(input logic [3:0] c, input logic [63:0] a, input logic [2:0] l);
    logic dual;
    q_cmd[q_n[7:0]] = c; q_addr[q_n[7:0]] = a[63:3]; q_len[q_n[7:0]] = l;
    q_n++;
    dual = (a[63:32] != 0) && c != C_FLUSH && c != C_FENCE;
    if (dual) begin
      e_cmd[exp_n[7:0]] = C_DUAL; e_ad[exp_n[7:0]] = {a[31:3], l};
      e_slot[exp_n[7:0]] = 1'b1; e_dual[exp_n[7:0]] = 1'b1; exp_n++;
      e_cmd[exp_n[7:0]] = c; e_ad[exp_n[7:0]] = a[63:32];
      e_slot[exp_n[7:0]] = 1'b0; e_dual[exp_n[7:0]] = 1'b1; exp_n++;
    end else begin
      e_cmd[exp_n[7:0]] = c; e_ad[exp_n[7:0]] = {a[31:3], l};
      e_slot[exp_n[7:0]] = (c != C_FENCE); e_dual[exp_n[7:0]] = 1'b0; exp_n++;
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    g_edge <= !gnt_n && bus_status == 3'b111;
    if (cyc == 150000) begin
      failures++;
      $display("FAIL R5 watchdog actual=%0d expected<%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_pipe && !pipe_n) chk(g_edge, "R3 burst start without grant", 0, 1);
      if (!prev_pipe && !prev_req) chk(!pipe_n, "R5 gap inside burst", pipe_n, 0);
      if (!prev_pipe && prev_req) chk(pipe_n, "R6 strobe after last word", pipe_n, 1);
      if (!prev_req && req_n) chk(!pipe_n, "R6 request released off last word", pipe_n, 0);
      if (!pipe_n) begin
        if (obs_i < exp_n) begin
          chk(bus_cmd == e_cmd[obs_i[7:0]], e_dual[obs_i[7:0]] ? "R7 cmd" : "R4 cmd",
              bus_cmd, e_cmd[obs_i[7:0]]);
          chk(bus_ad == e_ad[obs_i[7:0]], e_dual[obs_i[7:0]] ? "R7 ad" : "R4 ad",
              bus_ad, e_ad[obs_i[7:0]]);
          if (e_slot[obs_i[7:0]]) model_cnt++;
          chk(model_cnt <= depth_model, "R8 outstanding", model_cnt, depth_model);
        end else begin
          chk(1'b0, "R4 unexpected word", obs_i, exp_n);
        end
        obs_i++;
      end
    end
    prev_pipe = pipe_n;
    prev_req  = req_n;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_depth(input int v);
    @(negedge clk); cfg_we = 1'b1; cfg_depth = DEPTH_W'(v);
    @(negedge clk); cfg_we = 1'b0;
    depth_model = v;
  endtask

  task automatic wait_req();
    for (int i = 0; i < 50 && req_n; i++) @(negedge clk);
    chk(!req_n, "R3 request raised", req_n, 0);
  endtask

  task automatic grant();
    wait_req();
    gnt_n = 1'b0; bus_status = 3'b111;
    @(negedge clk); gnt_n = 1'b1; bus_status = 3'b000;
  endtask

  task automatic wait_words(input int target);
    for (int i = 0; i < 400 && obs_i < target; i++) @(negedge clk);
    tick(3);
  endtask

  task automatic free(input int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk); slot_free = 1'b1;
      chk(model_cnt > 0, "R8 count below zero", model_cnt, 1);
      model_cnt--;
      @(negedge clk); slot_free = 1'b0;
    end
  endtask

  initial begin
    int base;
    tick(3);
    chk(req_n && pipe_n, "R1 reset strobes", {req_n, pipe_n}, 2'b11);
    chk(bus_cmd == 0 && bus_ad == 0, "R1 reset bus", {bus_cmd, bus_ad}, 0);
    rst_n = 1'b1;
    tick(1);
    chk(req_n && pipe_n, "R1 after release", {req_n, pipe_n}, 2'b11);

    push_req(4'b0000, 64'h0000_0000_0001_0040, 3'd2);
    push_req(4'b0100, 64'h0000_0000_0002_0080, 3'd7);
    tick(20);
    chk(req_n && pipe_n, "R2 depth zero quiet", {req_n, pipe_n}, 2'b11);
    chk(obs_i == 0, "R2 no words", obs_i, 0);

    set_depth(4);
    grant(); wait_words(exp_n);
    chk(obs_i == 2, "R5 two-word burst", obs_i, 2);
    free(2);

    push_req(4'b0101, 64'h0000_0000_0000_1238, 3'd1);
    wait_req();
    gnt_n = 1'b0; bus_status = 3'b000;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); chk(pipe_n, "R3 wrong status", pipe_n, 1);
    end
    gnt_n = 1'b1; bus_status = 3'b111;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); chk(pipe_n, "R3 no grant", pipe_n, 1);
    end
    bus_status = 3'b000;
    grant(); wait_words(exp_n);
    chk(obs_i == exp_n, "R3 issued after grant", obs_i, exp_n);
    free(1);

    set_depth(200);
    base = obs_i;
    for (int i = 0; i < 64; i++) begin
      logic [31:0] hi;
      hi = (i % 4 == 3) ? 32'(i + 1) : 32'd0;
      push_req(CODES[i / 8], {hi, 32'(i * 32'h40 + 32'h1000)}, 3'(i % 8));
    end
    grant(); wait_words(exp_n);
    chk(obs_i == exp_n, "R5 sweep single burst", obs_i - base, exp_n - base);
    free(model_cnt);

    set_depth(2);
    base = obs_i;
    for (int i = 0; i < 5; i++) push_req(4'b0000, 64'(i * 8 + 8'h80), 3'd0);
    grant(); tick(10);
    chk(obs_i - base == 2, "R9 burst stops at depth", obs_i - base, 2);
    chk(req_n, "R9 request held off", req_n, 1);
    free(1); grant(); tick(10);
    chk(obs_i - base == 3, "R9 resume one", obs_i - base, 3);
    free(2); grant(); tick(10);
    chk(obs_i - base == 5, "R9 resume two", obs_i - base, 5);
    free(2);

    set_depth(1);
    base = obs_i;
    push_req(4'b0000, 64'h0000_0000_0000_0100, 3'd3);
    push_req(C_FENCE, 64'h0000_0000_0000_0000, 3'd0);
    push_req(4'b0000, 64'h0000_0000_0000_0200, 3'd3);
    grant(); tick(10);
    chk(obs_i - base == 2, "R10 fence passes full queue", obs_i - base, 2);
    free(1); grant(); tick(10); free(1);
    base = obs_i;
    push_req(C_FLUSH, 64'h0000_0005_0000_0040, 3'd0);
    push_req(4'b0000, 64'h0000_0000_0000_0300, 3'd0);
    grant(); tick(10);
    chk(obs_i - base == 1, "R10 flush takes slot single word", obs_i - base, 1);
    free(1); grant(); tick(10); free(1);

    base = obs_i;
    push_req(4'b1001, 64'h0000_00AB_1234_5678, 3'd5);
    push_req(4'b0000, 64'h0000_0000_0000_0400, 3'd0);
    grant(); tick(10);
    chk(obs_i - base == 2, "R7 pair uses one slot", obs_i - base, 2);
    free(1); grant(); tick(10); free(1);

    base = obs_i;
    for (int i = 0; i < 3; i++) push_req(4'b0100, 64'(i * 8 + 16'h500), 3'd1);
    wait_req();
    cfg_we = 1'b1; cfg_depth = 8'd3;
    @(negedge clk); cfg_we = 1'b0;
    grant(); tick(10);
    chk(obs_i - base == 1, "R11 busy depth write ignored", obs_i - base, 1);
    for (int i = 0; i < 2; i++) begin
      free(1); grant(); tick(10);
    end
    chk(obs_i - base == 3, "R11 remaining issued singly", obs_i - base, 3);
    free(1);
    tick(5);
    chk(obs_i == exp_n, "R4 all words seen", obs_i, exp_n);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule